// File: doc/BRIEF.md
# Motor-Driver Serial Chain Master

This block is the transmit side of a serial link to a chain of up to three stepper motor driver chips. A host supplies one packed payload per driver: two phase bits, a fast-decay bit and two DAC magnitude vectors. It also supplies a set of configuration inputs: a clock divider, a driver-count code, five polarity options and a chip-select mode. On a start pulse the block applies the configured inversions to every payload. It then shifts the words out most significant bit first on a divided shift clock and drives either one shared select or one select per driver.

The configuration inputs are sampled into an internal snapshot on every idle cycle and frozen while a frame is in flight. A reconfiguration therefore never corrupts a frame. Illegal settings are repaired in the snapshot and reported on an error output.

Top module: `motor_chain_master`

## Requirements
- R1: One shift-clock period lasts 2*(D+1) system clock cycles, where D is the divider input, and a divider below 7 is used as 7. The first active edge of a frame comes D+1 cycles after the clock edge that accepts the start pulse.
- R2: A frame carries N words of 11 bits, where N is the driver code plus one and code 3 is used as three drivers. Driver 0's word goes first, each word MSB first. Payload bits for driver k sit at payload_i[11k+10:11k], laid out as bit 10 phase A, bit 9 phase B, bit 8 fast decay, bits 7:4 DAC A and bits 3:0 DAC B.
- R3: With the phase-invert option set, bits 10 and 9 of every word are sent inverted.
- R4: With the fast-decay option set, bit 8 of every word is sent inverted, making fast decay active low.
- R5: With the DAC-invert option set, bits 7:0 of every word are sent inverted.
- R6: In shared mode, cs_o[0] is held at the level of the select-polarity input (0 active low, 1 active high) for the whole frame and at the opposite level when idle, and cs_o[2:1] stay high.
- R7: In individual mode, cs_o[k] is low exactly while driver k's word is shifted and high otherwise, and the select-polarity input has no effect.
- R8: The shift clock idles at the level of the clock-invert input. The active edge leaves that level, and sdo_o changes only on the returning edge, so it is stable at every active edge.
- R9: Configuration changes made during a frame do not alter that frame. They take effect for the next one.
- R10: cfg_err_o is high, one cycle after the inputs are seen in idle, when the divider is below 7, the driver code is 3, or individual mode is combined with the select-polarity input at 1. It holds its value during a frame.
- R11: A start pulse while busy_o is high is ignored and adds no bits to the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a frame when idle |
| payload_i | input | 33 | Three packed 11-bit driver payloads |
| cfg_div_i | input | 8 | Shift-clock divider |
| cfg_drv_code_i | input | 2 | Number of drivers minus one |
| cfg_cs_high_i | input | 1 | Shared select active high when 1 |
| cfg_sck_inv_i | input | 1 | Shift clock idles high when 1 |
| cfg_phase_inv_i | input | 1 | Invert phase bits |
| cfg_fd_low_i | input | 1 | Fast-decay bit active low |
| cfg_dac_inv_i | input | 1 | Invert DAC vectors |
| cfg_cs_split_i | input | 1 | One select per driver when 1 |
| busy_o | output | 1 | Frame in progress |
| sck_o | output | 1 | Shift clock |
| sdo_o | output | 1 | Serial data |
| cs_o | output | 3 | Chip selects |
| cfg_err_o | output | 1 | Configuration was repaired |

## Verification
The bench uses the default word layout: 4-bit DAC vectors, 11-bit words and three select lines. The divider ranges from below the minimum, through the clamp point of 7 and small odd and even values, up to 255. That covers the clamped, typical and slowest clock periods, and every active-edge spacing is timed. Driver codes 0 to 3 reach one-, two- and three-word frames, the illegal code, and the individual select walking across all three drivers. A frame with a mid-flight divider and DAC-polarity change plus a stray start pulse shows that the snapshot stays frozen.

// File: rtl/mcm_pkg.sv
package mcm_pkg;

    localparam int DIV_W   = 8;
    localparam int DAC_W   = 4;
    localparam int WORD_W  = 3 + 2 * DAC_W;
    localparam int MAX_DRV = 3;
    localparam int CODE_W  = 2;
    localparam int DIV_MIN = 7;
    localparam int FRAME_W = MAX_DRV * WORD_W;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [CODE_W-1:0] code;
        logic              cs_high;
        logic              sck_inv;
        logic              phase_inv;
        logic              fd_low;
        logic              dac_inv;
        logic              cs_split;
    } cfg_t;

    typedef struct packed {
        logic             ph_a;
        logic             ph_b;
        logic             fd;
        logic [DAC_W-1:0] dac_a;
        logic [DAC_W-1:0] dac_b;
    } word_t;

    function automatic logic cfg_bad(cfg_t c);
        return (c.div < DIV_W'(DIV_MIN)) ||
               (c.code == CODE_W'(MAX_DRV)) ||
               (c.cs_split && c.cs_high);
    endfunction

    function automatic cfg_t cfg_fix(cfg_t c);
        cfg_t r;
        r = c;
        if (c.div < DIV_W'(DIV_MIN)) r.div = DIV_W'(DIV_MIN);
        if (c.code > CODE_W'(MAX_DRV - 1)) r.code = CODE_W'(MAX_DRV - 1);
        if (c.cs_split) r.cs_high = 1'b0;
        return r;
    endfunction

    function automatic word_t apply_pol(word_t w, cfg_t c);
        word_t r;
        r.ph_a  = w.ph_a ^ c.phase_inv;
        r.ph_b  = w.ph_b ^ c.phase_inv;
        r.fd    = w.fd ^ c.fd_low;
        r.dac_a = w.dac_a ^ {DAC_W{c.dac_inv}};
        r.dac_b = w.dac_b ^ {DAC_W{c.dac_inv}};
        return r;
    endfunction

endpackage

// File: rtl/mcm_cfg_snap.sv
module mcm_cfg_snap
    import mcm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  cfg_t cfg_in,
    output cfg_t cfg_next,
    output cfg_t cfg_q,
    output logic err_q
);
    assign cfg_next = cfg_fix(cfg_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            cfg_q.div <= DIV_W'(DIV_MIN);
            err_q <= 1'b0;
        end else if (!hold) begin
            cfg_q <= cfg_next;
            err_q <= cfg_bad(cfg_in);
        end
    end
endmodule

// File: rtl/mcm_half_timer.sv
module mcm_half_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] cnt;

    assign tick = run && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt <= '0;
        else if (tick)    cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mcm_frame_shifter.sv
module mcm_frame_shifter #(
    parameter int WORD_W  = 11,
    parameter int MAX_DRV = 3,
    parameter int CODE_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  logic [MAX_DRV*WORD_W-1:0] frame_in,
    input  logic [CODE_W-1:0]         last_word,
    input  logic                      tick,
    output logic                      busy,
    output logic                      sck_raw,
    output logic                      sdo,
    output logic [CODE_W-1:0]         word_idx
);
    localparam int FW   = MAX_DRV * WORD_W;
    localparam int BC_W = $clog2(WORD_W);
    localparam logic [BC_W-1:0] LAST_BIT = BC_W'(WORD_W - 1);

    typedef enum logic { ST_IDLE, ST_SHIFT } st_e;

    st_e               st;
    logic [FW-1:0]     sreg;
    logic [BC_W-1:0]   bit_cnt;
    logic [CODE_W-1:0] stop_word;

    assign busy = (st == ST_SHIFT);
    assign sdo  = busy ? sreg[FW-1] : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            sreg      <= '0;
            bit_cnt   <= '0;
            word_idx  <= '0;
            stop_word <= '0;
            sck_raw   <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    sck_raw <= 1'b0;
                    if (load) begin
                        st        <= ST_SHIFT;
                        sreg      <= frame_in;
                        bit_cnt   <= '0;
                        word_idx  <= '0;
                        stop_word <= last_word;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!sck_raw) begin
                            sck_raw <= 1'b1;
                        end else begin
                            sck_raw <= 1'b0;
                            sreg    <= sreg << 1;
                            if (bit_cnt == LAST_BIT) begin
                                bit_cnt <= '0;
                                if (word_idx == stop_word) begin
                                    st       <= ST_IDLE;
                                    word_idx <= '0;
                                end else begin
                                    word_idx <= word_idx + 1'b1;
                                end
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/motor_chain_master.sv
module motor_chain_master
    import mcm_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 start_i,
    input  logic [FRAME_W-1:0]   payload_i,
    input  logic [DIV_W-1:0]     cfg_div_i,
    input  logic [CODE_W-1:0]    cfg_drv_code_i,
    input  logic                 cfg_cs_high_i,
    input  logic                 cfg_sck_inv_i,
    input  logic                 cfg_phase_inv_i,
    input  logic                 cfg_fd_low_i,
    input  logic                 cfg_dac_inv_i,
    input  logic                 cfg_cs_split_i,
    output logic                 busy_o,
    output logic                 sck_o,
    output logic                 sdo_o,
    output logic [MAX_DRV-1:0]   cs_o,
    output logic                 cfg_err_o
);
    cfg_t              cfg_in, cfg_next, cfg_q;
    logic [FRAME_W-1:0] frame_w;
    logic              busy, tick, sck_raw, load;
    logic [CODE_W-1:0] word_idx;

    always_comb begin
        cfg_in.div       = cfg_div_i;
        cfg_in.code      = cfg_drv_code_i;
        cfg_in.cs_high   = cfg_cs_high_i;
        cfg_in.sck_inv   = cfg_sck_inv_i;
        cfg_in.phase_inv = cfg_phase_inv_i;
        cfg_in.fd_low    = cfg_fd_low_i;
        cfg_in.dac_inv   = cfg_dac_inv_i;
        cfg_in.cs_split  = cfg_cs_split_i;
    end

    assign load = start_i && !busy;

    mcm_cfg_snap i_snap (
        .clk      (clk_i),
        .rst      (rst_i),
        .hold     (busy),
        .cfg_in   (cfg_in),
        .cfg_next (cfg_next),
        .cfg_q    (cfg_q),
        .err_q    (cfg_err_o)
    );

    generate
        for (genvar k = 0; k < MAX_DRV; k++) begin : g_word
            assign frame_w[FRAME_W-1-k*WORD_W -: WORD_W] =
                apply_pol(word_t'(payload_i[k*WORD_W +: WORD_W]), cfg_next);
        end
    endgenerate

    mcm_half_timer #(.W(DIV_W)) i_timer (
        .clk   (clk_i),
        .rst   (rst_i),
        .run   (busy),
        .limit (cfg_q.div),
        .tick  (tick)
    );

    mcm_frame_shifter #(
        .WORD_W  (WORD_W),
        .MAX_DRV (MAX_DRV),
        .CODE_W  (CODE_W)
    ) i_shift (
        .clk       (clk_i),
        .rst       (rst_i),
        .load      (load),
        .frame_in  (frame_w),
        .last_word (cfg_next.code),
        .tick      (tick),
        .busy      (busy),
        .sck_raw   (sck_raw),
        .sdo       (sdo_o),
        .word_idx  (word_idx)
    );

    assign busy_o = busy;
    assign sck_o  = sck_raw ^ cfg_q.sck_inv;

    generate
        for (genvar k = 0; k < MAX_DRV; k++) begin : g_cs
            if (k == 0) begin : g_first
                assign cs_o[k] = cfg_q.cs_split
                               ? !(busy && word_idx == CODE_W'(k))
                               : (busy ? cfg_q.cs_high : !cfg_q.cs_high);
            end else begin : g_rest
                assign cs_o[k] = cfg_q.cs_split
                               ? !(busy && word_idx == CODE_W'(k))
                               : 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/mcm_chain_checker.sv
module mcm_chain_checker
    import mcm_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               busy,
    input logic               sck_raw,
    input logic               sck,
    input logic               sdo,
    input logic [MAX_DRV-1:0] cs,
    input cfg_t               cfg
);
    // R8: data holds across the active edge
    p_sdo_stable_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(sck_raw) |-> $stable(sdo));

    // R8: clock rests at its idle level outside a frame
    p_sck_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> sck == cfg.sck_inv);

    // R7: exactly one select low in individual mode
    p_cs_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && cfg.cs_split) |-> $countones(cs) == MAX_DRV - 1);

    // R6: shared select inactive between frames
    p_cs_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy && !cfg.cs_split) |-> cs[0] == !cfg.cs_high);

    // R9: applied configuration frozen within a frame
    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cfg));

    // R1: clamped divider is never below the minimum while shifting
    p_div_clamp_r1: assert property (@(posedge clk) disable iff (rst)
        busy |-> cfg.div >= DIV_W'(DIV_MIN));
endmodule

bind motor_chain_master mcm_chain_checker i_chk (
    .clk     (clk_i),
    .rst     (rst_i),
    .busy    (busy),
    .sck_raw (sck_raw),
    .sck     (sck_o),
    .sdo     (sdo_o),
    .cs      (cs_o),
    .cfg     (cfg_q)
);

// File: tb/test_motor_chain_master.sv
module test_motor_chain_master;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [32:0] payload = '0;
    logic [7:0]  div = 8'd7;
    logic [1:0]  code = '0;
    logic        pcs = 0, psck = 0, pph = 0, pfd = 0, pdac = 0, split = 0;
    logic        busy, sck, sdo, err;
    logic [2:0]  cs;

    typedef struct { logic d; logic [2:0] cs; int gap; string tag; } exp_t;
    exp_t q[$];

    int  n_chk = 0, n_fail = 0, cyc = 0, ref_cyc = 0;
    logic exp_psck = 0, prev_raw = 0;
    bit  done = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    motor_chain_master i_motor_chain_master (
        .clk_i(clk), .rst_i(rst), .start_i(start), .payload_i(payload),
        .cfg_div_i(div), .cfg_drv_code_i(code), .cfg_cs_high_i(pcs),
        .cfg_sck_inv_i(psck), .cfg_phase_inv_i(pph), .cfg_fd_low_i(pfd),
        .cfg_dac_inv_i(pdac), .cfg_cs_split_i(split),
        .busy_o(busy), .sck_o(sck), .sdo_o(sdo), .cs_o(cs), .cfg_err_o(err)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: pop one expected bit at every active edge
    always @(negedge clk) begin
        logic raw;
        if (!rst) begin
            raw = sck ^ exp_psck;
            if (busy && raw && !prev_raw) begin
                if (q.size() == 0) begin
                    chk("R11 extra bit", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk({e.tag, " sdo R2"}, int'(sdo), int'(e.d));
                    chk("R6 R7 cs", int'(cs), int'(e.cs));
                    chk("R1 period", cyc - ref_cyc, e.gap);
                end
                ref_cyc = cyc;
            end
            prev_raw = raw;
        end
    end

    task automatic run_frame(input logic [7:0] d, input logic [1:0] c,
                             input logic s_cs, s_sck, s_ph, s_fd, s_dac, s_split,
                             input logic [32:0] pay, input bit mid);
        int eff, n;
        logic [10:0] w, mask;
        logic [2:0] cs_act, cs_idle;
        @(negedge clk);
        div = d; code = c; pcs = s_cs; psck = s_sck; pph = s_ph;
        pfd = s_fd; pdac = s_dac; split = s_split; payload = pay;
        exp_psck = s_sck;
        @(negedge clk); @(negedge clk);
        chk("R10 cfg_err", int'(err),
            int'(d < 7 || c == 2'd3 || (s_split && s_cs)));
        eff  = (d < 7) ? 7 : int'(d);
        n    = (c == 2'd3) ? 3 : int'(c) + 1;
        mask = {s_ph, s_ph, s_fd, {8{s_dac}}};
        cs_idle = s_split ? 3'b111 : (s_cs ? 3'b110 : 3'b111);
        for (int k = 0; k < n; k++) begin
            w = pay[k*11 +: 11] ^ mask;
            cs_act = s_split ? ~(3'b001 << k) : (s_cs ? 3'b111 : 3'b110);
            for (int b = 10; b >= 0; b--) begin
                exp_t e;
                e.d = w[b]; e.cs = cs_act;
                e.gap = (k == 0 && b == 10) ? eff + 2 : 2 * (eff + 1);
                e.tag = "R3 R4 R5";
                q.push_back(e);
            end
        end
        start = 1'b1; ref_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        if (mid) begin
            repeat (30) @(negedge clk);
            pdac = ~pdac; div = 8'd20;      // R9 mid-frame change
            start = 1'b1;                   // R11 start while busy
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        chk("R2 frame bits all sent", q.size(), 0);
        chk("R8 sck idle", int'(sck), int'(s_sck));
        chk("R6 R7 cs idle", int'(cs), int'(cs_idle));
        chk("R8 sdo idle", int'(sdo), 0);
        q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 reset sck", int'(sck), 0);
        chk("R6 reset cs", int'(cs), 3'b111);
        chk("R11 reset busy", int'(busy), 0);
        chk("R10 reset err", int'(err), 0);
        run_frame(8'd7,   2'd0, 0, 0, 0, 0, 0, 0, 33'h0_0000_05A3, 0);
        run_frame(8'd9,   2'd2, 1, 1, 1, 0, 0, 0, 33'h1_2345_6789, 0);
        run_frame(8'd3,   2'd3, 0, 0, 0, 1, 1, 1, 33'h0_F0F0_1234, 0);
        run_frame(8'd12,  2'd1, 1, 0, 0, 0, 0, 1, 33'h0_003C_7A55, 0);
        run_frame(8'd8,   2'd2, 0, 1, 0, 1, 0, 0, 33'h1_AAAA_5555, 1);
        run_frame(8'd255, 2'd0, 0, 0, 1, 0, 1, 0, 33'h0_0000_0601, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule